// File: doc/BRIEF.md
# MAC Interrupt Status and Receive Error Statistics Unit

This block gathers the event strobes of a 10/100 Ethernet MAC into one interrupt line and a set of small error counters. The receive path, the transmit path and the management (MDIO) interface each send one-cycle strobes: transmit done, receive done, transmit chaining error, management transaction complete, and the four receive error kinds (bad CRC, framing error, receive overflow, missed packet). Each completion strobe sets a sticky bit in a status register. The status register is cleared by writing ones to it. An enable register with the same bit layout selects which status bits drive the interrupt output.

The four error kinds are counted in 8-bit counters. The CRC, framing and overflow counts are packed into one word, and the missed-packet count sits in a word of its own. Reading either word returns the counts and zeroes them. When a counter wraps past its maximum, a dedicated rollover status bit is set, and so is a summary error bit. Software can then add a full counter span to its own totals. Writing a one to the top bit of the status word does not store anything. It sends a one-cycle poll request to the transmit engine instead. All access goes through a simple 32-bit, word-indexed register port. Read data is registered and appears one cycle after the read strobe.

Top module: `mac_evt_unit`

## Requirements
- R1: After reset, the status and enable registers are 0, every counter is 0, the interrupt line is low and the poll request is low.
- R2: A strobe on the transmit-done, receive-done, transmit-chaining-error or management-done input sets status bit 0, 1, 3 or 12 respectively. The bit is visible one cycle later and stays set until it is cleared.
- R3: The enable register (word 2) uses the status bit layout. Only the implemented bits (mask 0x0000171F) are stored and read back. The interrupt output is high exactly when some status bit and its enable bit are both set.
- R4: Each strobe on the CRC, framing or overflow error input adds one to its 8-bit counter. Word 5 reads these counters as bits 7:0 (CRC), 15:8 (framing) and 23:16 (overflow), with the upper bits 0. Word 6 reads the missed-packet counter in bits 7:0.
- R5: A counter increment from 255 to 0 sets that counter's rollover status bit, which is bit 4 for missed packets, bit 8 for CRC, bit 9 for framing and bit 10 for overflow. The same increment also sets the summary error bit 2.
- R6: A write to the status register (word 1) clears every implemented bit written as 1. Bits written as 0 keep their value.
- R7: A write to word 1 with bit 31 set produces a poll request pulse exactly one cycle long, in the cycle after the write. Bit 31 is not stored and always reads 0.
- R8: Reading word 5 returns the CRC, framing and overflow counts and zeroes all three. Reading word 6 does the same for the missed-packet count. A strobe in the same cycle as the read is not lost: that counter reads 1 afterwards.
- R9: If an event strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Word 0 reads the constant identifier `ID_VALUE` (default 0x0005AC01). Words 3, 4 and 7 and above read 0. Writes to words 0, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word index of the register being accessed |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data appears on reg_rdata in the next cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, held until the next read |
| ev_tx_done | input | 1 | Transmit completion strobe |
| ev_rx_done | input | 1 | Receive completion strobe |
| ev_tx_chain_err | input | 1 | Transmit descriptor chaining error strobe |
| ev_mgmt_done | input | 1 | Management transaction complete strobe |
| ev_crc_err | input | 1 | Received frame with bad CRC |
| ev_frame_err | input | 1 | Received frame with framing error |
| ev_ovfl_err | input | 1 | Receive overflow |
| ev_missed | input | 1 | Packet missed for lack of a buffer |
| irq | output | 1 | Interrupt request |
| tx_poll | output | 1 | One-cycle transmit poll request |

## Verification
Two pairs of functions can collide in one cycle, and the bench forces each collision with a single drive.

The first pair is a completion strobe and a software clear of the same status bit. The bench asserts the receive-done strobe while writing 1 to bit 1 of the status word. It judges the result by reading status back: bit 1 must still be set.

The second pair is a counter read and a new error on the same counter. The bench raises the CRC strobe in the cycle that word 5 is read. The read must return the count from before that cycle, and a second read must return 1.

// File: rtl/mac_evt_pkg.sv
package mac_evt_pkg;

    localparam int REG_W = 32;

    // status / enable bit positions
    localparam int B_TXDONE   = 0;
    localparam int B_RXDONE   = 1;
    localparam int B_ERRSUM   = 2;
    localparam int B_TXCHAIN  = 3;
    localparam int B_MISSWRAP = 4;
    localparam int B_CRCWRAP  = 8;
    localparam int B_FRMWRAP  = 9;
    localparam int B_OVFWRAP  = 10;
    localparam int B_MGMT     = 12;
    localparam int B_POLL     = 31;

    localparam logic [REG_W-1:0] STAT_IMPL =
        (REG_W'(1) << B_TXDONE)   | (REG_W'(1) << B_RXDONE)  |
        (REG_W'(1) << B_ERRSUM)   | (REG_W'(1) << B_TXCHAIN) |
        (REG_W'(1) << B_MISSWRAP) | (REG_W'(1) << B_CRCWRAP) |
        (REG_W'(1) << B_FRMWRAP)  | (REG_W'(1) << B_OVFWRAP) |
        (REG_W'(1) << B_MGMT);

    // word offsets of the register port
    localparam int OFS_ID   = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_EN   = 2;
    localparam int OFS_ERRS = 5;
    localparam int OFS_MISS = 6;

    // counter slots; the first three share the packed word in this order
    localparam int NUM_CNT  = 4;
    localparam int NUM_PACK = 3;
    localparam int CNT_CRC  = 0;
    localparam int CNT_FRM  = 1;
    localparam int CNT_OVF  = 2;
    localparam int CNT_MISS = 3;

endpackage

// File: rtl/mac_evt_counter.sv
module mac_evt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            // a strobe arriving with the clearing read is counted
            cnt_d.cnt = inc ? CNT_W'(1) : '0;
        end else if (inc) begin
            cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt  = cnt_q.cnt;
    assign wrap = inc && !clr && (cnt_q.cnt == '1);

endmodule

// File: rtl/mac_evt_status.sv
module mac_evt_status #(
    parameter int              NB   = 32,
    parameter logic [NB-1:0]   IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_vec,
    input  logic [NB-1:0] clr_vec,
    output logic [NB-1:0] stat
);

    typedef struct packed {
        logic [NB-1:0] bits;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set: a same-cycle event wins
        st_d.bits = ((st_q.bits & ~clr_vec) | set_vec) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.bits;

endmodule

// File: rtl/mac_evt_unit.sv
module mac_evt_unit
    import mac_evt_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          CNT_W    = 8,
    parameter logic [31:0] ID_VALUE = 32'h0005_AC01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_tx_done,
    input  logic              ev_rx_done,
    input  logic              ev_tx_chain_err,
    input  logic              ev_mgmt_done,
    input  logic              ev_crc_err,
    input  logic              ev_frame_err,
    input  logic              ev_ovfl_err,
    input  logic              ev_missed,
    output logic              irq,
    output logic              tx_poll
);

    // the packed error word must hold three counters
    localparam int PACK_BITS = NUM_PACK * CNT_W;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] rdata;
        logic             poll;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] rd_mux;

    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_clr;
    logic [NUM_CNT-1:0] cnt_wrap;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    logic sel_stat, sel_en, sel_errs, sel_miss;

    assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign sel_en   = (reg_addr == ADDR_W'(OFS_EN));
    assign sel_errs = (reg_addr == ADDR_W'(OFS_ERRS));
    assign sel_miss = (reg_addr == ADDR_W'(OFS_MISS));

    // ---------------------------------------------------------------
    // error counters
    // ---------------------------------------------------------------
    always_comb begin
        cnt_inc           = '0;
        cnt_inc[CNT_CRC]  = ev_crc_err;
        cnt_inc[CNT_FRM]  = ev_frame_err;
        cnt_inc[CNT_OVF]  = ev_ovfl_err;
        cnt_inc[CNT_MISS] = ev_missed;
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        if (gi < NUM_PACK) begin : g_packed
            assign cnt_clr[gi] = reg_rd && sel_errs;
        end else begin : g_alone
            assign cnt_clr[gi] = reg_rd && sel_miss;
        end

        mac_evt_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[gi]),
            .clr   (cnt_clr[gi]),
            .cnt   (cnt_val[gi]),
            .wrap  (cnt_wrap[gi])
        );
    end

    // ---------------------------------------------------------------
    // status register
    // ---------------------------------------------------------------
    always_comb begin
        set_vec             = '0;
        set_vec[B_TXDONE]   = ev_tx_done;
        set_vec[B_RXDONE]   = ev_rx_done;
        set_vec[B_TXCHAIN]  = ev_tx_chain_err;
        set_vec[B_MGMT]     = ev_mgmt_done;
        set_vec[B_CRCWRAP]  = cnt_wrap[CNT_CRC];
        set_vec[B_FRMWRAP]  = cnt_wrap[CNT_FRM];
        set_vec[B_OVFWRAP]  = cnt_wrap[CNT_OVF];
        set_vec[B_MISSWRAP] = cnt_wrap[CNT_MISS];
        set_vec[B_ERRSUM]   = |cnt_wrap;
    end

    assign clr_vec = (reg_wr && sel_stat) ? reg_wdata : '0;

    mac_evt_status #(
        .NB   (REG_W),
        .IMPL (STAT_IMPL)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat    (stat_q)
    );

    // ---------------------------------------------------------------
    // read multiplexer
    // ---------------------------------------------------------------
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADDR_W'(OFS_ID):   rd_mux = ID_VALUE;
            ADDR_W'(OFS_STAT): rd_mux = stat_q;
            ADDR_W'(OFS_EN):   rd_mux = top_q.en;
            ADDR_W'(OFS_ERRS): begin
                for (int i = 0; i < NUM_PACK; i++) begin
                    rd_mux[i*CNT_W +: CNT_W] = cnt_val[i];
                end
            end
            ADDR_W'(OFS_MISS): rd_mux[CNT_W-1:0] = cnt_val[CNT_MISS];
            default:           rd_mux = '0;
        endcase
    end

    // ---------------------------------------------------------------
    // enable, read data and poll pulse
    // ---------------------------------------------------------------
    always_comb begin
        top_d      = top_q;
        top_d.poll = reg_wr && sel_stat && reg_wdata[B_POLL];
        if (reg_wr && sel_en) begin
            top_d.en = reg_wdata & STAT_IMPL;
        end
        if (reg_rd) begin
            top_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign en_q      = top_q.en;
    assign reg_rdata = top_q.rdata;
    assign tx_poll   = top_q.poll;
    assign irq       = |(stat_q & en_q);

    if (PACK_BITS > REG_W) begin : g_width_bad
        $error("three counters of CNT_W bits do not fit one register word");
    end

endmodule

// File: rtl/mac_evt_unit_chk.sv
module mac_evt_unit_chk #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [31:0]       reg_wdata,
    input logic              ev_tx_done,
    input logic              ev_rx_done,
    input logic              ev_crc_err,
    input logic              irq,
    input logic              tx_poll,
    input logic [31:0]       stat_q,
    input logic [31:0]       en_q,
    input logic [CNT_W-1:0]  crc_cnt
);

    // R2
    tx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> stat_q[0]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_done && reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[1]) |=> stat_q[1]);

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[0] && !ev_tx_done) |=> !stat_q[0]);

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    // R7
    poll_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[31]));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(5) && !ev_crc_err) |=> (crc_cnt == '0));

    // R5
    wrap_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[8]) |-> stat_q[2]);

    // R7
    poll_unstored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[31]);

endmodule

bind mac_evt_unit mac_evt_unit_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .ev_tx_done (ev_tx_done),
    .ev_rx_done (ev_rx_done),
    .ev_crc_err (ev_crc_err),
    .irq        (irq),
    .tx_poll    (tx_poll),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .crc_cnt    (cnt_val[0])
);

// File: tb/mac_evt_unit_tb.sv
module mac_evt_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EXP_ID   = 32'h0005_AC01;
    localparam logic [31:0] EXP_IMPL = 32'h0000_171F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_tx_done = 1'b0, ev_rx_done = 1'b0, ev_tx_chain_err = 1'b0, ev_mgmt_done = 1'b0;
    logic        ev_crc_err = 1'b0, ev_frame_err = 1'b0, ev_ovfl_err = 1'b0, ev_missed = 1'b0;
    logic        irq, tx_poll;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_evt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_tx_chain_err(ev_tx_chain_err),
        .ev_mgmt_done(ev_mgmt_done), .ev_crc_err(ev_crc_err), .ev_frame_err(ev_frame_err),
        .ev_ovfl_err(ev_ovfl_err), .ev_missed(ev_missed), .irq(irq), .tx_poll(tx_poll)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        wr_reg(4'd1, 32'hFFFF_FFFF);
        wr_reg(4'd2, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 tx_poll", {31'b0, tx_poll}, 32'h0);
        rd_reg(4'd1, d); check("R1 status", d, 32'h0);
        rd_reg(4'd2, d); check("R1 enable", d, 32'h0);
        rd_reg(4'd5, d); check("R1 error counters", d, 32'h0);
        rd_reg(4'd6, d); check("R1 missed counter", d, 32'h0);
        rd_reg(4'd0, d); check("R10 id", d, EXP_ID);
    endtask

    task automatic t_events();
        logic [31:0] d;
        ev_tx_done = 1'b1; ev_rx_done = 1'b1; ev_tx_chain_err = 1'b1; ev_mgmt_done = 1'b1;
        @(negedge clk);
        ev_tx_done = 1'b0; ev_rx_done = 1'b0; ev_tx_chain_err = 1'b0; ev_mgmt_done = 1'b0;
        check("R2 sticky after strobe, no enable -> irq low R3", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        rd_reg(4'd1, d); check("R2 status bits 0,1,3,12", d, 32'h0000_100B);
        wr_reg(4'd2, 32'h0000_0002);
        check("R3 irq with rx enable", {31'b0, irq}, 32'h1);
        wr_reg(4'd2, 32'h0000_0004);
        check("R3 irq with unrelated enable", {31'b0, irq}, 32'h0);
        wr_reg(4'd2, 32'hFFFF_FFFF);
        rd_reg(4'd2, d); check("R3 enable readback mask", d, EXP_IMPL);
        wr_reg(4'd2, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr_reg(4'd1, 32'h0000_0001);
        rd_reg(4'd1, d); check("R6 clear bit 0 only", d, 32'h0000_100A);
        wr_reg(4'd1, 32'h0);
        rd_reg(4'd1, d); check("R6 write zero no effect", d, 32'h0000_100A);
        check("R7 no poll without bit 31", {31'b0, tx_poll}, 32'h0);
        wr_reg(4'd1, 32'h0000_100A);
        rd_reg(4'd1, d); check("R6 clear remaining", d, 32'h0);
    endtask

    task automatic t_counters();
        logic [31:0] d;
        for (int i = 0; i < 7; i++) begin
            ev_crc_err = (i < 3); ev_frame_err = (i < 5); ev_ovfl_err = 1'b1; ev_missed = (i < 2);
            @(negedge clk);
        end
        ev_crc_err = 1'b0; ev_frame_err = 1'b0; ev_ovfl_err = 1'b0; ev_missed = 1'b0;
        rd_reg(4'd5, d); check("R4 packed counters", d, 32'h0007_0503);
        rd_reg(4'd5, d); check("R8 packed counters cleared by read", d, 32'h0);
        rd_reg(4'd6, d); check("R4 missed counter", d, 32'h0000_0002);
        rd_reg(4'd6, d); check("R8 missed cleared by read", d, 32'h0);
    endtask

    task automatic t_read_with_event();
        logic [31:0] d;
        ev_crc_err = 1'b1;
        repeat (4) @(negedge clk);
        reg_addr = 4'd5; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; ev_crc_err = 1'b0;
        d = reg_rdata;
        check("R8 read returns count before colliding strobe", d, 32'h0000_0004);
        rd_reg(4'd5, d); check("R8 colliding strobe counted", d, 32'h0000_0001);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        ev_crc_err = 1'b1; ev_frame_err = 1'b1; ev_ovfl_err = 1'b1; ev_missed = 1'b1;
        repeat (255) @(negedge clk);
        ev_crc_err = 1'b0; ev_frame_err = 1'b0; ev_ovfl_err = 1'b0; ev_missed = 1'b0;
        rd_reg(4'd1, d); check("R5 no rollover at 255", d, 32'h0);
        ev_crc_err = 1'b1; ev_frame_err = 1'b1; ev_ovfl_err = 1'b1; ev_missed = 1'b1;
        @(negedge clk);
        ev_crc_err = 1'b0; ev_frame_err = 1'b0; ev_ovfl_err = 1'b0; ev_missed = 1'b0;
        rd_reg(4'd1, d); check("R5 rollover bits 2,4,8,9,10", d, 32'h0000_0714);
        rd_reg(4'd5, d); check("R5 packed counters wrapped to 0", d, 32'h0);
        rd_reg(4'd6, d); check("R5 missed wrapped to 0", d, 32'h0);
        wr_reg(4'd2, 32'h0000_0004);
        check("R3 irq from summary error", {31'b0, irq}, 32'h1);
        clear_all();
    endtask

    task automatic t_poll();
        logic [31:0] d;
        reg_addr = 4'd1; reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R7 poll pulse high", {31'b0, tx_poll}, 32'h1);
        @(negedge clk);
        check("R7 poll pulse one cycle", {31'b0, tx_poll}, 32'h0);
        rd_reg(4'd1, d); check("R7 bit 31 reads 0", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        ev_rx_done = 1'b1;
        @(negedge clk);
        ev_rx_done = 1'b0;
        ev_rx_done = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h0000_0002; reg_wr = 1'b1;
        @(negedge clk);
        ev_rx_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd_reg(4'd1, d); check("R9 set wins over clear", d, 32'h0000_0002);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        ev_missed = 1'b1;
        @(negedge clk);
        ev_missed = 1'b0;
        rd_reg(4'd3, d); check("R10 word 3 reads 0", d, 32'h0);
        rd_reg(4'd9, d); check("R10 word 9 reads 0", d, 32'h0);
        wr_reg(4'd0, 32'h1234_5678);
        rd_reg(4'd0, d); check("R10 id unchanged by write", d, EXP_ID);
        wr_reg(4'd6, 32'h0000_00FF);
        rd_reg(4'd6, d); check("R10 missed unchanged by write", d, 32'h0000_0001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_counters();
        t_read_with_event();
        t_wrap();
        t_poll();
        t_set_wins();
        t_unmapped();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule